// File: doc/BRIEF.md
# Integer Subset Instruction Decoder

This block turns one 32-bit instruction word of a small integer instruction set into the fields and control strobes that the datapath needs. It is purely combinational and has no clock or reset. It extracts the register indices, the shift amount and the 26-bit jump target. It extends the 16-bit immediate, using zero-extension for the two logical-immediate operations and sign-extension for every other word. It selects an ALU operation code and raises a single strobe for each kind of action.

An execute or memory stage that sits after an instruction register uses these outputs directly. Any opcode or R-type function code outside the supported set raises `illegal_o` and clears every strobe, so a trap can be taken without side effects.

Top module: `insn_decoder`

## Requirements
- R1: `src_a_o` equals instr[25:21], `src_b_o` equals instr[20:16], `shamt_o` equals instr[10:6] and `jump_tgt_o` equals instr[25:0], for every word.
- R2: With opcode instr[31:26]=0x00, the funct values in instr[5:0] map as follows: add 0x20 to ALU 0, sub 0x22 to ALU 1, and 0x24 to ALU 2, or 0x25 to ALU 3, xor 0x26 to ALU 4, nor 0x27 to ALU 5, slt 0x2A to ALU 6, sll 0x00 to ALU 7 and srl 0x02 to ALU 8. Each of these sets `reg_we_o` and drives `dst_o` with instr[15:11].
- R3: Opcode 0x00 with funct 0x18 (multiply, ALU 9) or funct 0x1A (divide, ALU 10) sets `hilo_we_o` and clears `reg_we_o`.
- R4: Opcode 0x00 with funct 0x08 sets `jump_reg_o`, clears `reg_we_o` and drives ALU 15 (no operation).
- R5: Opcode 0x08 (add immediate, ALU 0), 0x0A (set-less-than immediate, ALU 6), 0x0C (and immediate, ALU 2) and 0x0D (or immediate, ALU 3) set `reg_we_o` and drive `dst_o` with instr[20:16].
- R6: For opcodes 0x0C and 0x0D, `imm_o` is instr[15:0] with bits [31:16] zero. For every other word, `imm_o` is instr[15:0] sign-extended from bit 15.
- R7: Opcode 0x23 (load) sets `mem_rd_o` and `reg_we_o`, drives `dst_o` with instr[20:16] and selects ALU 0. Opcode 0x2B (store) sets `mem_wr_o`, clears `reg_we_o` and selects ALU 0.
- R8: Opcode 0x04 sets `branch_o`. Opcode 0x05 sets both `branch_o` and `branch_ne_o`. Both select ALU 1 and clear `reg_we_o`.
- R9: Opcode 0x02 sets `jump_o`, clears `reg_we_o` and drives ALU 15.
- R10: Any other opcode, or opcode 0x00 with any other funct, sets `illegal_o`, clears every other strobe and drives ALU 15 and `dst_o`=0.
- R11: At most one of `mem_rd_o`, `mem_wr_o`, `branch_o`, `jump_o`, `jump_reg_o`, `hilo_we_o` and `illegal_o` is high. `dst_o` is 0 whenever `reg_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| src_a_o | output | 5 | First source register index |
| src_b_o | output | 5 | Second source register index |
| dst_o | output | 5 | Destination register index, 0 when no write |
| imm_o | output | 32 | Extended immediate |
| shamt_o | output | 5 | Shift amount field |
| jump_tgt_o | output | 26 | Jump target field |
| alu_op_o | output | 4 | ALU operation code |
| reg_we_o | output | 1 | General register write |
| mem_rd_o | output | 1 | Memory load |
| mem_wr_o | output | 1 | Memory store |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch taken on inequality |
| jump_o | output | 1 | Absolute jump |
| jump_reg_o | output | 1 | Jump through register |
| hilo_we_o | output | 1 | HI/LO pair write |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The immediate checks assume that `instr_i` holds a known two-state value whenever they are evaluated. A word containing X would make the case decode and the one-hot check meaningless. The bench always drives fully defined words, starting with the all-zero word while reset is held, and it changes the input only between samples. This lets the combinational outputs settle before any check reads them. Coverage comes from a vector table with one entry per supported encoding, together with exhaustive sweeps over all 64 opcodes and all 64 funct codes.

// File: rtl/insn_dec_pkg.sv
`timescale 1ns/1ps
package insn_dec_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned OPW    = 6;
  localparam int unsigned REGW   = 5;
  localparam int unsigned IMMW   = 16;
  localparam int unsigned TGTW   = 26;
  localparam int unsigned ALUW   = 4;

  // primary opcodes
  localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPW-1:0] OP_J     = 6'h02;
  localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPW-1:0] OP_BNE   = 6'h05;
  localparam logic [OPW-1:0] OP_ADDI  = 6'h08;
  localparam logic [OPW-1:0] OP_SLTI  = 6'h0A;
  localparam logic [OPW-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OPW-1:0] OP_ORI   = 6'h0D;
  localparam logic [OPW-1:0] OP_LW    = 6'h23;
  localparam logic [OPW-1:0] OP_SW    = 6'h2B;

  // R-type function codes
  localparam logic [OPW-1:0] FN_SLL  = 6'h00;
  localparam logic [OPW-1:0] FN_SRL  = 6'h02;
  localparam logic [OPW-1:0] FN_JR   = 6'h08;
  localparam logic [OPW-1:0] FN_MULT = 6'h18;
  localparam logic [OPW-1:0] FN_DIV  = 6'h1A;
  localparam logic [OPW-1:0] FN_ADD  = 6'h20;
  localparam logic [OPW-1:0] FN_SUB  = 6'h22;
  localparam logic [OPW-1:0] FN_AND  = 6'h24;
  localparam logic [OPW-1:0] FN_OR   = 6'h25;
  localparam logic [OPW-1:0] FN_XOR  = 6'h26;
  localparam logic [OPW-1:0] FN_NOR  = 6'h27;
  localparam logic [OPW-1:0] FN_SLT  = 6'h2A;

  typedef enum logic [ALUW-1:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_AND = 4'd2,
    ALU_OR  = 4'd3,
    ALU_XOR = 4'd4,
    ALU_NOR = 4'd5,
    ALU_SLT = 4'd6,
    ALU_SLL = 4'd7,
    ALU_SRL = 4'd8,
    ALU_MUL = 4'd9,
    ALU_DIV = 4'd10,
    ALU_NOP = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic reg_we;
    logic dst_rd;    // 1: rd field, 0: rt field
    logic mem_rd;
    logic mem_wr;
    logic branch;
    logic branch_ne;
    logic jump;
    logic jump_reg;
    logic hilo_we;
    logic illegal;
  } dec_ctl_t;
endpackage

// File: rtl/insn_dec_fields.sv
`timescale 1ns/1ps
module insn_dec_fields
  import insn_dec_pkg::*;
#(
  parameter int unsigned W_XLEN = XLEN,
  parameter int unsigned W_REG  = REGW,
  parameter int unsigned W_IMM  = IMMW,
  parameter int unsigned W_TGT  = TGTW
) (
  input  logic [W_XLEN-1:0] instr_i,
  input  logic              zero_ext_i,
  output logic [W_REG-1:0]  rs_o,
  output logic [W_REG-1:0]  rt_o,
  output logic [W_REG-1:0]  rd_o,
  output logic [W_REG-1:0]  shamt_o,
  output logic [W_TGT-1:0]  tgt_o,
  output logic [W_XLEN-1:0] imm_o
);
  localparam int unsigned RS_LSB = W_TGT - W_REG;
  localparam int unsigned RT_LSB = RS_LSB - W_REG;
  localparam int unsigned RD_LSB = RT_LSB - W_REG;
  localparam int unsigned SH_LSB = RD_LSB - W_REG;

  assign rs_o    = instr_i[RS_LSB +: W_REG];
  assign rt_o    = instr_i[RT_LSB +: W_REG];
  assign rd_o    = instr_i[RD_LSB +: W_REG];
  assign shamt_o = instr_i[SH_LSB +: W_REG];
  assign tgt_o   = instr_i[W_TGT-1:0];

  logic ext_bit;
  assign ext_bit = instr_i[W_IMM-1] & ~zero_ext_i;

  assign imm_o[W_IMM-1:0] = instr_i[W_IMM-1:0];
  for (genvar b = W_IMM; b < W_XLEN; b++) begin : g_ext
    assign imm_o[b] = ext_bit;
  end
endmodule

// File: rtl/insn_dec_ctrl.sv
`timescale 1ns/1ps
module insn_dec_ctrl
  import insn_dec_pkg::*;
(
  input  logic [OPW-1:0] opcode_i,
  input  logic [OPW-1:0] funct_i,
  output dec_ctl_t       ctl_o,
  output alu_op_e        alu_op_o,
  output logic           zero_ext_o
);
  always_comb begin
    ctl_o      = '0;
    alu_op_o   = ALU_NOP;
    zero_ext_o = 1'b0;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctl_o.reg_we = 1'b1;
        ctl_o.dst_rd = 1'b1;
        unique case (funct_i)
          FN_ADD:  alu_op_o = ALU_ADD;
          FN_SUB:  alu_op_o = ALU_SUB;
          FN_AND:  alu_op_o = ALU_AND;
          FN_OR:   alu_op_o = ALU_OR;
          FN_XOR:  alu_op_o = ALU_XOR;
          FN_NOR:  alu_op_o = ALU_NOR;
          FN_SLT:  alu_op_o = ALU_SLT;
          FN_SLL:  alu_op_o = ALU_SLL;
          FN_SRL:  alu_op_o = ALU_SRL;
          FN_MULT, FN_DIV: begin
            ctl_o.reg_we  = 1'b0;
            ctl_o.dst_rd  = 1'b0;
            ctl_o.hilo_we = 1'b1;
            alu_op_o      = (funct_i == FN_MULT) ? ALU_MUL : ALU_DIV;
          end
          FN_JR: begin
            ctl_o.reg_we   = 1'b0;
            ctl_o.dst_rd   = 1'b0;
            ctl_o.jump_reg = 1'b1;
          end
          default: begin
            ctl_o.reg_we  = 1'b0;
            ctl_o.dst_rd  = 1'b0;
            ctl_o.illegal = 1'b1;
          end
        endcase
      end
      OP_ADDI: begin ctl_o.reg_we = 1'b1; alu_op_o = ALU_ADD; end
      OP_SLTI: begin ctl_o.reg_we = 1'b1; alu_op_o = ALU_SLT; end
      OP_ANDI: begin ctl_o.reg_we = 1'b1; alu_op_o = ALU_AND; zero_ext_o = 1'b1; end
      OP_ORI:  begin ctl_o.reg_we = 1'b1; alu_op_o = ALU_OR;  zero_ext_o = 1'b1; end
      OP_LW: begin
        ctl_o.reg_we = 1'b1;
        ctl_o.mem_rd = 1'b1;
        alu_op_o     = ALU_ADD;
      end
      OP_SW: begin ctl_o.mem_wr = 1'b1; alu_op_o = ALU_ADD; end
      OP_BEQ: begin ctl_o.branch = 1'b1; alu_op_o = ALU_SUB; end
      OP_BNE: begin
        ctl_o.branch    = 1'b1;
        ctl_o.branch_ne = 1'b1;
        alu_op_o        = ALU_SUB;
      end
      OP_J:    ctl_o.jump    = 1'b1;
      default: ctl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_decoder.sv
`timescale 1ns/1ps
module insn_decoder
  import insn_dec_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output logic [REGW-1:0] src_a_o,
  output logic [REGW-1:0] src_b_o,
  output logic [REGW-1:0] dst_o,
  output logic [XLEN-1:0] imm_o,
  output logic [REGW-1:0] shamt_o,
  output logic [TGTW-1:0] jump_tgt_o,
  output logic [ALUW-1:0] alu_op_o,
  output logic            reg_we_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            branch_o,
  output logic            branch_ne_o,
  output logic            jump_o,
  output logic            jump_reg_o,
  output logic            hilo_we_o,
  output logic            illegal_o
);
  dec_ctl_t        ctl;
  alu_op_e         alu_op;
  logic            zero_ext;
  logic [REGW-1:0] rd_idx;

  insn_dec_ctrl u_ctrl (
    .opcode_i   (instr_i[XLEN-1 -: OPW]),
    .funct_i    (instr_i[OPW-1:0]),
    .ctl_o      (ctl),
    .alu_op_o   (alu_op),
    .zero_ext_o (zero_ext)
  );

  insn_dec_fields u_fields (
    .instr_i    (instr_i),
    .zero_ext_i (zero_ext),
    .rs_o       (src_a_o),
    .rt_o       (src_b_o),
    .rd_o       (rd_idx),
    .shamt_o    (shamt_o),
    .tgt_o      (jump_tgt_o),
    .imm_o      (imm_o)
  );

  assign dst_o       = ctl.reg_we ? (ctl.dst_rd ? rd_idx : src_b_o) : '0;
  assign alu_op_o    = alu_op;
  assign reg_we_o    = ctl.reg_we;
  assign mem_rd_o    = ctl.mem_rd;
  assign mem_wr_o    = ctl.mem_wr;
  assign branch_o    = ctl.branch;
  assign branch_ne_o = ctl.branch_ne;
  assign jump_o      = ctl.jump;
  assign jump_reg_o  = ctl.jump_reg;
  assign hilo_we_o   = ctl.hilo_we;
  assign illegal_o   = ctl.illegal;

  always_comb begin
    // R10
    illegal_quiet_chk: assert (!illegal_o || !(reg_we_o | mem_rd_o | mem_wr_o | branch_o |
                                               branch_ne_o | jump_o | jump_reg_o | hilo_we_o))
      else $error("illegal word with active strobe");
    // R11
    one_action_chk: assert ($onehot0({mem_rd_o, mem_wr_o, branch_o, jump_o, jump_reg_o,
                                      hilo_we_o, illegal_o}))
      else $error("more than one action strobe");
    // R6
    zero_ext_chk: assert (!(instr_i[XLEN-1 -: OPW] inside {OP_ANDI, OP_ORI}) ||
                          imm_o[XLEN-1:IMMW] == '0)
      else $error("logical immediate not zero-extended");
    // R7
    load_dst_chk: assert (!mem_rd_o || (reg_we_o && dst_o == instr_i[20:16]))
      else $error("load does not target rt");
    // R3
    hilo_excl_chk: assert (!hilo_we_o || !reg_we_o)
      else $error("HI/LO write with register write");
    // R11
    idle_dst_chk: assert (reg_we_o || dst_o == '0)
      else $error("destination index without write");
  end
endmodule

// File: tb/insn_decoder_tb_top.sv
`timescale 1ns/1ps
module insn_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  src_a, src_b, dst, shamt;
  logic [31:0] imm;
  logic [25:0] tgt;
  logic [3:0]  alu;
  logic reg_we, mem_rd, mem_wr, branch, branch_ne, jump, jump_reg, hilo_we, illegal;

  insn_decoder dut_i (
    .instr_i(instr), .src_a_o(src_a), .src_b_o(src_b), .dst_o(dst), .imm_o(imm),
    .shamt_o(shamt), .jump_tgt_o(tgt), .alu_op_o(alu), .reg_we_o(reg_we),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .branch_o(branch), .branch_ne_o(branch_ne),
    .jump_o(jump), .jump_reg_o(jump_reg), .hilo_we_o(hilo_we), .illegal_o(illegal)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [31:0] instr;
    logic [8:0]  ctl;   // reg_we,mem_rd,mem_wr,branch,branch_ne,jump,jump_reg,hilo_we,illegal
    logic [3:0]  alu;
    logic [4:0]  dst;
    logic [31:0] imm;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    // R2: rs=3 rt=7 rd=12 shamt=9
    '{32'h00676260, 9'b100000000, 4'd0,  5'd12, 32'h00006260, 4'd2},
    '{32'h00676262, 9'b100000000, 4'd1,  5'd12, 32'h00006262, 4'd2},
    '{32'h00676264, 9'b100000000, 4'd2,  5'd12, 32'h00006264, 4'd2},
    '{32'h00676265, 9'b100000000, 4'd3,  5'd12, 32'h00006265, 4'd2},
    '{32'h00676266, 9'b100000000, 4'd4,  5'd12, 32'h00006266, 4'd2},
    '{32'h00676267, 9'b100000000, 4'd5,  5'd12, 32'h00006267, 4'd2},
    '{32'h0067626A, 9'b100000000, 4'd6,  5'd12, 32'h0000626A, 4'd2},
    '{32'h00676240, 9'b100000000, 4'd7,  5'd12, 32'h00006240, 4'd2},
    '{32'h00676242, 9'b100000000, 4'd8,  5'd12, 32'h00006242, 4'd2},
    // R3
    '{32'h00676258, 9'b000000010, 4'd9,  5'd0,  32'h00006258, 4'd3},
    '{32'h0067625A, 9'b000000010, 4'd10, 5'd0,  32'h0000625A, 4'd3},
    // R4
    '{32'h00676248, 9'b000000100, 4'd15, 5'd0,  32'h00006248, 4'd4},
    // R10: bad funct
    '{32'h00676261, 9'b000000001, 4'd15, 5'd0,  32'h00006261, 4'd10},
    // R5
    '{32'h20677FFF, 9'b100000000, 4'd0,  5'd7,  32'h00007FFF, 4'd5},
    '{32'h2867FFFF, 9'b100000000, 4'd6,  5'd7,  32'hFFFFFFFF, 4'd5},
    // R6
    '{32'h3067F00F, 9'b100000000, 4'd2,  5'd7,  32'h0000F00F, 4'd6},
    '{32'h34678000, 9'b100000000, 4'd3,  5'd7,  32'h00008000, 4'd6},
    '{32'h20678001, 9'b100000000, 4'd0,  5'd7,  32'hFFFF8001, 4'd6},
    // R7
    '{32'h8C678004, 9'b110000000, 4'd0,  5'd7,  32'hFFFF8004, 4'd7},
    '{32'hAC670010, 9'b001000000, 4'd0,  5'd0,  32'h00000010, 4'd7},
    // R8
    '{32'h1067FFFE, 9'b000100000, 4'd1,  5'd0,  32'hFFFFFFFE, 4'd8},
    '{32'h14670003, 9'b000110000, 4'd1,  5'd0,  32'h00000003, 4'd8},
    // R9
    '{32'h08671234, 9'b000001000, 4'd15, 5'd0,  32'h00001234, 4'd9},
    // R10: bad opcodes
    '{32'hFC67ABCD, 9'b000000001, 4'd15, 5'd0,  32'hFFFFABCD, 4'd10},
    '{32'h0467ABCD, 9'b000000001, 4'd15, 5'd0,  32'hFFFFABCD, 4'd10}
  };

  function automatic logic [8:0] ctl_now();
    return {reg_we, mem_rd, mem_wr, branch, branch_ne, jump, jump_reg, hilo_we, illegal};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic chk_fields(input string req);
    // R1
    chk(src_a == instr[25:21] && src_b == instr[20:16] && shamt == instr[10:6] && tgt == instr[25:0],
        req, {src_a, src_b, shamt, tgt}, {instr[25:21], instr[20:16], instr[10:6], instr[25:0]});
  endtask

  function automatic bit op_legal(input logic [5:0] op);
    return op inside {6'h00, 6'h02, 6'h04, 6'h05, 6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h23, 6'h2B};
  endfunction

  function automatic bit fn_legal(input logic [5:0] fn);
    return fn inside {6'h00, 6'h02, 6'h08, 6'h18, 6'h1A, 6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A};
  endfunction

  initial begin
    instr = 32'h0;
    // all-zero word during reset: legal shift, writes index 0 (R2, R11)
    repeat (2) @(posedge clk);
    #1;
    chk(ctl_now() == 9'b100000000 && alu == 4'd7 && dst == 5'd0 && imm == 32'h0,
        "R2 reset-word", {ctl_now(), alu, dst, imm}, {9'b100000000, 4'd7, 5'd0, 32'h0});
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      apply(VEC[i].instr);
      chk(ctl_now() == VEC[i].ctl && alu == VEC[i].alu && dst == VEC[i].dst && imm == VEC[i].imm,
          tag, {ctl_now(), alu, dst, imm}, {VEC[i].ctl, VEC[i].alu, VEC[i].dst, VEC[i].imm});
      chk_fields("R1");
    end

    // R10: all-ones word
    apply(32'hFFFFFFFF);
    chk(ctl_now() == 9'b000000001 && alu == 4'd15 && dst == 5'd0 && imm == 32'hFFFFFFFF,
        "R10 all-ones", {ctl_now(), alu, dst, imm}, {9'b000000001, 4'd15, 5'd0, 32'hFFFFFFFF});
    chk_fields("R1");

    // R10 opcode sweep, funct fixed to add
    for (int op = 0; op < 64; op++) begin
      apply({op[5:0], 5'd1, 5'd2, 5'd3, 5'd0, 6'h20});
      chk(illegal == !op_legal(op[5:0]), "R10 opcode sweep", {58'd0, op[5:0]}, {63'd0, !op_legal(op[5:0])});
      // R11
      chk(reg_we || dst == 5'd0, "R11 idle dst", {59'd0, dst}, 64'd0);
    end

    // R10 funct sweep under opcode 0
    for (int fn = 0; fn < 64; fn++) begin
      apply({6'h00, 5'd4, 5'd5, 5'd6, 5'd2, fn[5:0]});
      chk(illegal == !fn_legal(fn[5:0]), "R10 funct sweep", {58'd0, fn[5:0]}, {63'd0, !fn_legal(fn[5:0])});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule